// File: doc/BRIEF.md
# Microcontroller ALU with Flag Register

This block is the arithmetic and logic stage of a small microcontroller, together with its carry and zero flags. During each enabled cycle it takes a 6-bit opcode, the value of the destination register and two candidate second operands. One candidate is the 8-bit constant from the instruction word. The other is the value of the source register. The lowest opcode bit picks between them.

It supports four operations:
- bitwise AND
- addition without an incoming carry
- addition with the current carry flag
- compare

It drives the result and a write-back strobe to the register file in the same cycle. Both of these outputs are combinational. The flags are registered and update at the next rising clock edge.

Compare only affects the flags and never asks for a write-back. An opcode the block does not recognise leaves the flags unchanged and produces no write-back. A cycle without the execute enable does the same. The register file, the scratchpad and instruction fetch are outside this block.

The reset input clears the flags asynchronously. Its release passes through an internal two-stage synchroniser.

Top module: `mcu_alu_core`

## Requirements
- R1: While reset is low, and for two clock edges after it rises, carry and zero read 0.
- R2: When opcode bit 0 is 1, the second operand is `src_val`. When it is 0, the second operand is `imm_val`.
- R3: AND (opcodes 6'b001010 and 6'b001011) outputs `dst_val & operand`. It clears carry and sets zero exactly when that result is 0.
- R4: ADD (opcodes 6'b011000 and 6'b011001) outputs `dst_val + operand` truncated to the data width. It sets carry to the carry-out and sets zero when the truncated result is 0.
- R5: ADDCY (opcodes 6'b011010 and 6'b011011) outputs `dst_val + operand + carry`, using the registered carry from before the operation. Its flags follow the R4 rule.
- R6: COMPARE (opcodes 6'b010100 and 6'b010101) keeps `wr_en` low. It sets zero when the operand equals `dst_val`, and sets carry when the operand is greater than `dst_val` as unsigned numbers.
- R7: `wr_en` is high in the same cycle exactly when `exec_en` is high and the opcode is one of AND, ADD or ADDCY.
- R8: When `exec_en` is low, or the opcode is none of the eight listed codes, the flags keep their value and `wr_en` is low.
- R9: Result and `wr_en` are combinational. The flags change only at the rising clock edge that ends the enabled cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| exec_en | input | 1 | Execute enable for the current cycle |
| opcode | input | 6 | Instruction opcode field |
| dst_val | input | DATA_W | Destination register value |
| src_val | input | DATA_W | Source register value |
| imm_val | input | DATA_W | Constant from the instruction |
| result | output | DATA_W | Operation result |
| wr_en | output | 1 | Write-back strobe for the destination register |
| carry | output | 1 | Registered carry flag |
| zero | output | 1 | Registered zero flag |

## Verification
The bench builds the block with the default 8-bit data width. At that width it can drive every wrap-around boundary directly:
- 8'hFF plus one
- carry-in that pushes 8'hFE past the top
- compares at equality and one apart on either side

A reference model in the bench carries the flag state across cycles. This lets it check ADDCY chains that run through disabled and unrecognised cycles. A reset applied mid-run checks that the flags clear and that the synchronised release holds them cleared.

// File: rtl/mcu_alu_pkg.sv
package mcu_alu_pkg;

  typedef enum logic [1:0] {
    OP_AND  = 2'd0,
    OP_CMP  = 2'd1,
    OP_ADD  = 2'd2,
    OP_ADDC = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic    valid;
    logic    use_reg;
    alu_op_e op;
  } alu_dec_t;

  // Even member of each opcode pair; bit 0 selects the register operand.
  localparam logic [5:0] OPC_AND  = 6'b001010;
  localparam logic [5:0] OPC_CMP  = 6'b010100;
  localparam logic [5:0] OPC_ADD  = 6'b011000;
  localparam logic [5:0] OPC_ADDC = 6'b011010;

endpackage

// File: rtl/mcu_alu_rst_sync.sv
module mcu_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mcu_alu_decode.sv
module mcu_alu_decode
  import mcu_alu_pkg::*;
(
  input  logic [5:0] opcode,
  output alu_dec_t   dec
);
  always_comb begin
    dec.valid   = 1'b1;
    dec.use_reg = opcode[0];
    dec.op      = OP_AND;
    unique case (opcode[5:1])
      OPC_AND[5:1]:  dec.op = OP_AND;
      OPC_CMP[5:1]:  dec.op = OP_CMP;
      OPC_ADD[5:1]:  dec.op = OP_ADD;
      OPC_ADDC[5:1]: dec.op = OP_ADDC;
      default:       dec.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/mcu_alu_datapath.sv
module mcu_alu_datapath
  import mcu_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_dec_t            dec,
  input  logic [DATA_W-1:0]   dst_val,
  input  logic [DATA_W-1:0]   src_val,
  input  logic [DATA_W-1:0]   imm_val,
  input  logic                carry_in,
  output logic [DATA_W-1:0]   result,
  output logic                c_new,
  output logic                z_new
);
  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] opnd_b;
  logic [EXT_W-1:0]  sum_ext;
  logic [EXT_W-1:0]  diff_ext;
  logic              cin;

  assign opnd_b   = dec.use_reg ? src_val : imm_val;
  assign cin      = (dec.op == OP_ADDC) ? carry_in : 1'b0;
  assign sum_ext  = {1'b0, dst_val} + {1'b0, opnd_b} + {{DATA_W{1'b0}}, cin};
  assign diff_ext = {1'b0, dst_val} - {1'b0, opnd_b};

  always_comb begin
    result = '0;
    c_new  = 1'b0;
    z_new  = 1'b0;
    unique case (dec.op)
      OP_AND: begin
        result = dst_val & opnd_b;
        c_new  = 1'b0;
        z_new  = (result == '0);
      end
      OP_CMP: begin
        result = diff_ext[DATA_W-1:0];
        c_new  = diff_ext[DATA_W];
        z_new  = (dst_val == opnd_b);
      end
      default: begin
        result = sum_ext[DATA_W-1:0];
        c_new  = sum_ext[DATA_W];
        z_new  = (sum_ext[DATA_W-1:0] == '0);
      end
    endcase
  end
endmodule

// File: rtl/mcu_alu_flag_reg.sv
module mcu_alu_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en,
  input  logic c_new,
  input  logic z_new,
  output logic carry_q,
  output logic zero_q
);
  logic carry_d, zero_d;

  always_comb begin
    carry_d = carry_q;
    zero_d  = zero_q;
    if (upd_en) begin
      carry_d = c_new;
      zero_d  = z_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      carry_q <= carry_d;
      zero_q  <= zero_d;
    end
  end
endmodule

// File: rtl/mcu_alu_core.sv
module mcu_alu_core
  import mcu_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [5:0]        opcode,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] imm_val,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              carry,
  output logic              zero
);
  alu_dec_t dec;
  logic     rst_sync_n;
  logic     c_new, z_new, upd_en;

  mcu_alu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mcu_alu_decode u_dec (.opcode(opcode), .dec(dec));

  mcu_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .dec(dec), .dst_val(dst_val), .src_val(src_val), .imm_val(imm_val),
    .carry_in(carry), .result(result), .c_new(c_new), .z_new(z_new)
  );

  assign upd_en = exec_en & dec.valid;
  assign wr_en  = upd_en & (dec.op != OP_CMP);

  mcu_alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_sync_n), .upd_en(upd_en),
    .c_new(c_new), .z_new(z_new), .carry_q(carry), .zero_q(zero)
  );

  // R6: compare never requests write-back
  a_r6_cmp_no_wb: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opcode[5:1] == OPC_CMP[5:1]) |-> !wr_en);

  // R7: no write-back without execute enable
  a_r7_wb_needs_en: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> exec_en);

  // R8: disabled cycle keeps flags
  a_r8_hold_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !exec_en |=> ($stable(carry) && $stable(zero)));

  // R3: AND clears carry
  a_r3_and_clears_carry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && opcode[5:1] == OPC_AND[5:1]) |=> !carry);

  // R4: zero flag tracks the written result of an addition
  a_r4_add_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && opcode[5:1] == OPC_ADD[5:1]) |=> (zero == ($past(result) == '0)));

  // R1: flags are clear while held in reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_sync_n |-> (!carry && !zero));
endmodule

// File: tb/mcu_alu_core_bench.sv
module mcu_alu_core_bench;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 14;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         exec_en;
  logic [5:0]   opcode;
  logic [W-1:0] dst_val, src_val, imm_val;
  logic [W-1:0] result;
  logic         wr_en, carry, zero;

  int checks = 0;
  int errors = 0;
  logic mc, mz;
  bit done = 1'b0;

  // {exec_en, opcode, dst, src, imm}
  localparam logic [30:0] TBL [NVEC] = '{
    {1'b1, 6'b011000, 8'h10, 8'h99, 8'h05},
    {1'b1, 6'b011001, 8'hF0, 8'h20, 8'h01},
    {1'b1, 6'b011010, 8'h01, 8'h00, 8'h01},
    {1'b1, 6'b011000, 8'hFF, 8'h00, 8'h01},
    {1'b1, 6'b011011, 8'hFE, 8'h01, 8'h00},
    {1'b1, 6'b001010, 8'hF0, 8'hFF, 8'h0F},
    {1'b1, 6'b001011, 8'h3C, 8'hF5, 8'h00},
    {1'b1, 6'b010100, 8'h40, 8'h00, 8'h40},
    {1'b1, 6'b010101, 8'h40, 8'h41, 8'h00},
    {1'b1, 6'b010100, 8'h41, 8'h00, 8'h40},
    {1'b1, 6'b011000, 8'hFF, 8'h00, 8'hFF},
    {1'b0, 6'b001010, 8'h00, 8'h00, 8'h00},
    {1'b1, 6'b111111, 8'h00, 8'h00, 8'h00},
    {1'b1, 6'b011010, 8'h00, 8'h00, 8'h00}
  };

  mcu_alu_core #(.DATA_W(W)) u_mcu_alu_core (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
    .dst_val(dst_val), .src_val(src_val), .imm_val(imm_val),
    .result(result), .wr_en(wr_en), .carry(carry), .zero(zero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(logic en, logic [5:0] op, logic [W-1:0] d,
                         logic [W-1:0] s, logic [W-1:0] i);
    logic [W-1:0] b, er;
    logic [W:0]   ext;
    logic         known, ewr, ec, ez;
    string        tag;
    @(negedge clk);
    exec_en = en; opcode = op; dst_val = d; src_val = s; imm_val = i;
    b     = op[0] ? s : i;               // R2
    known = 1'b1; ewr = 1'b0; er = '0; ec = mc; ez = mz; tag = "R8";
    case (op[5:1])
      5'b00101: begin er = d & b; ec = 1'b0; ez = (er == '0); ewr = 1'b1; tag = "R3"; end
      5'b01100: begin ext = {1'b0, d} + {1'b0, b}; er = ext[W-1:0];
                      ec = ext[W]; ez = (er == '0); ewr = 1'b1; tag = "R4"; end
      5'b01101: begin ext = {1'b0, d} + {1'b0, b} + {{W{1'b0}}, mc}; er = ext[W-1:0];
                      ec = ext[W]; ez = (er == '0); ewr = 1'b1; tag = "R5"; end
      5'b01010: begin ec = (b > d); ez = (b == d); tag = "R6"; end
      default:  known = 1'b0;
    endcase
    if (!en || !known) begin ewr = 1'b0; ec = mc; ez = mz; tag = "R8"; end
    #1;
    check(en && known ? "R7" : "R8", "wr_en", W'(wr_en), W'(ewr));
    if (ewr) check(op[0] ? "R2" : tag, "result", result, er);
    check("R9", "carry before edge", W'(carry), W'(mc));
    @(posedge clk); #1;
    check(tag, "carry", W'(carry), W'(ec));
    check(tag, "zero", W'(zero), W'(ez));
    mc = ec; mz = ez;
  endtask

  initial begin
    rst_n = 1'b0; exec_en = 1'b0; opcode = '0;
    dst_val = '0; src_val = '0; imm_val = '0;
    mc = 1'b0; mz = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "carry in reset", W'(carry), '0);
    check("R1", "zero in reset", W'(zero), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NVEC; k++)
      run_vec(TBL[k][30], TBL[k][29:24], TBL[k][23:16], TBL[k][15:8], TBL[k][7:0]);

    // Set both flags, then reset mid-run with enabled updates pending
    run_vec(1'b1, 6'b011000, 8'hFF, 8'h00, 8'h01);
    @(negedge clk);
    rst_n = 1'b0; exec_en = 1'b1; opcode = 6'b011000; dst_val = 8'hFF; imm_val = 8'h01;
    #1;
    check("R1", "carry async clear", W'(carry), '0);
    check("R1", "zero async clear", W'(zero), '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "carry held during sync release", W'(carry), '0);
    check("R1", "zero held during sync release", W'(zero), '0);
    @(negedge clk);
    mc = 1'b0; mz = 1'b0;
    exec_en = 1'b0;

    // ADDCY right after reset sees carry 0
    run_vec(1'b1, 6'b011011, 8'h7F, 8'h80, 8'h00);
    // Register/immediate selection with distinct values
    run_vec(1'b1, 6'b001010, 8'hFF, 8'h0F, 8'hF0);
    run_vec(1'b1, 6'b010101, 8'h05, 8'h05, 8'h06);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule